// File: doc/BRIEF.md
# Motion Compensation Residual Reconstruction

This block rebuilds the decoded pixels of one 4:2:0 macroblock. A macroblock is six 8x8 blocks taken in a fixed order: four luma blocks (k = 0..3) followed by two chroma blocks (k = 4 for the blue-difference block and k = 5 for the red-difference block). For every pixel, the block takes a predicted value from the upstream interpolation stage and adds an inverse-transform residual that it fetches from a local residual RAM. The sum is saturated to an 8-bit pixel.

Each macroblock begins with a start pulse. The pulse carries a 6-bit coded-block pattern and a word base address for the residual RAM. The RAM always keeps one 64-word slot per block, even for blocks that have no residual. The block reads the RAM only for blocks whose pattern bit is set. For every other block it uses a zero residual, so the output equals the prediction.

Residual fetch starts as soon as the macroblock starts and runs ahead of the prediction stream. A small FIFO holds the prefetched residuals, so input stalls and output backpressure lose no data. A one-cycle done pulse marks the end of the macroblock.

Top module: `mc_recon`

## Requirements
- R1: While reset is held and after it is released, `ram_rd_en_o`, `out_valid_o`, `pred_ready_o` and `done_o` are 0 until a start pulse is accepted.
- R2: The RAM is read only inside the 384-word window that starts at the latched base. It is read only for blocks whose pattern bit is 1. Over one macroblock there are exactly 64 reads per coded block.
- R3: Pattern bit 5-k belongs to block k. Bit 5 is the first luma block and bit 0 is the last chroma block. The residual of sample i (0..63, raster order) of block k sits at word address base + 64*k + i. Reads are issued in increasing address order.
- R4: Each 16-bit two's-complement residual (bit 15 is the sign) is first saturated to the range -256..+255.
- R5: An output pixel equals the predicted pixel plus the saturated residual, saturated to 0..255.
- R6: For a block whose pattern bit is 0, the output pixel equals the predicted pixel, whatever the RAM holds.
- R7: Output pixels pair with predictions one for one, in sample order 0..383. The prediction tag (3 bits) carries the block index k, and it must equal k for samples 64k..64k+63.
- R8: `done_o` is high for exactly one cycle. That cycle is the one after the handshake of the 384th output pixel, and the block is idle from then on.
- R9: Residual fetch runs ahead of the prediction stream. With no prediction offered, the block issues FIFO_DEPTH reads when the first block is coded. With `out_ready_i` low, `pred_ready_o` is low.
- R10: A start pulse that arrives while a macroblock is in progress is ignored. Pattern, base and the read sequence are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start-of-macroblock pulse |
| cbp_i | input | 6 | Coded-block pattern, latched on an accepted start |
| base_i | input | AW | Residual RAM word base address, latched on an accepted start |
| ram_rd_en_o | output | 1 | Residual RAM read enable |
| ram_addr_o | output | AW | Residual RAM word address |
| ram_rdata_i | input | 16 | Residual RAM read data, one cycle after the enable |
| pred_valid_i | input | 1 | Predicted pixel valid |
| pred_ready_o | output | 1 | Predicted pixel accepted |
| pred_data_i | input | 8 | Predicted pixel value |
| pred_blk_i | input | 3 | Block index tag of the predicted pixel |
| out_valid_o | output | 1 | Reconstructed pixel valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | 8 | Reconstructed pixel |
| done_o | output | 1 | One-cycle end-of-macroblock pulse |

## Verification
Assertions check on every cycle that the residual FIFO never overflows or underflows, that uncoded blocks pass the prediction straight through, and that the prediction tag matches the current block. They also check that the done pulse lasts one cycle and follows a handshake, and that a start during a busy macroblock leaves the latched pattern alone. The bench scenarios show the behaviours that need a reference model: both saturation stages across extreme residuals and predictions, the exact address sequence and read count for each pattern and base, the prefetch depth reached while the prediction stream is idle, and the ordering of pixels under random input and output stalls.

// File: rtl/mcr_pkg.sv
`timescale 1ns/1ps
// Shared widths and the saturating arithmetic of the reconstruction path.
// Assumes 16-bit two's-complement residuals and 8-bit unsigned pixels.
package mcr_pkg;
    localparam int RES_W = 16;
    localparam int PIX_W = 8;

    // Saturate a raw residual to the signed 9-bit range -256..255.
    function automatic logic signed [9:0] sat_res(input logic signed [RES_W-1:0] r);
        if (r > 16'sd255)
            return 10'sd255;
        else if (r < -16'sd256)
            return -10'sd256;
        else
            return r[9:0];
    endfunction

    // Add a saturated residual to a prediction and saturate to 0..255.
    function automatic logic [PIX_W-1:0] add_pix(input logic [PIX_W-1:0] p,
                                                 input logic signed [9:0] r);
        logic signed [10:0] s;
        s = $signed({3'b000, p}) + $signed({r[9], r});
        if (s < 11'sd0)
            return 8'd0;
        else if (s > 11'sd255)
            return 8'hFF;
        else
            return s[7:0];
    endfunction
endpackage

// File: rtl/mcr_fifo.sv
`timescale 1ns/1ps
// Small synchronous FIFO that holds prefetched residuals.
// Assumes the writer never pushes into a full FIFO and the reader never
// pops an empty one; both are guarded by assertions.
module mcr_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          empty,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    // Store the pushed word.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);

    // R9: prefetch must never overrun the FIFO.
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CW'(DEPTH)) || pop);
    // R9: the consumer only pops what was prefetched.
    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
endmodule

// File: rtl/mcr_fetch.sv
`timescale 1ns/1ps
// Residual fetcher: walks the 384 sample slots in order. For each coded slot
// it issues a RAM read at base + slot; for each uncoded slot it injects a
// zero. The result reaches the FIFO one cycle later. A read is issued only
// while the FIFO plus the word in flight leave room.
// Assumes the RAM has a one-cycle read latency.
module mcr_fetch #(
    parameter int NUM_BLK     = 6,
    parameter int BLK_SAMPLES = 64,
    parameter int AW          = 10,
    parameter int DEPTH       = 4,
    localparam int CW         = $clog2(DEPTH + 1),
    localparam int TOTAL      = NUM_BLK * BLK_SAMPLES,
    localparam int IW         = $clog2(TOTAL),
    localparam int SH         = $clog2(BLK_SAMPLES),
    localparam int BW         = $clog2(NUM_BLK)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      go,
    input  logic [NUM_BLK-1:0]        coded_map,
    input  logic [AW-1:0]             base,
    input  logic [CW-1:0]             fifo_cnt,
    input  logic [mcr_pkg::RES_W-1:0] ram_rdata,
    output logic                      ram_rd_en,
    output logic [AW-1:0]             ram_addr,
    output logic                      push,
    output logic [mcr_pkg::RES_W-1:0] push_data
);
    logic          fetching;
    logic [IW-1:0] fidx;
    logic          s1_valid, s1_zero;
    logic [BW-1:0] blk;
    logic          coded, room, issue;
    logic [CW:0]   occ;

    assign blk   = BW'(fidx >> SH);
    assign coded = coded_map[blk];
    assign occ   = (CW+1)'(fifo_cnt) + (CW+1)'(s1_valid);
    assign room  = occ < (CW+1)'(DEPTH);
    assign issue = fetching && room;

    assign ram_rd_en = issue && coded;
    assign ram_addr  = base + AW'(fidx);

    // Step through the sample slots and track the word in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetching <= 1'b0;
            fidx     <= '0;
            s1_valid <= 1'b0;
            s1_zero  <= 1'b0;
        end else begin
            s1_valid <= issue;
            s1_zero  <= !coded;
            if (go) begin
                fetching <= 1'b1;
                fidx     <= '0;
            end else if (issue) begin
                fidx <= fidx + 1'b1;
                if (fidx == IW'(TOTAL - 1)) fetching <= 1'b0;
            end
        end
    end

    assign push      = s1_valid;
    assign push_data = s1_zero ? '0 : ram_rdata;

    // R3: consecutive reads inside one block step by exactly one word.
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_en && $past(ram_rd_en) && $past(issue) && ((ram_addr - base) % AW'(BLK_SAMPLES) != '0)
        |-> ram_addr == $past(ram_addr) + 1'b1);
endmodule

// File: rtl/mc_recon.sv
`timescale 1ns/1ps
// Top of the residual reconstruction block. It latches the pattern and base
// on an accepted start, lets the fetcher prefetch residuals into the FIFO,
// and pairs each FIFO head with one predicted pixel to form an output pixel.
// Assumes predictions arrive in sample order with a correct block tag.
module mc_recon #(
    parameter int NUM_BLK     = 6,
    parameter int BLK_SAMPLES = 64,
    parameter int AW          = 10,
    parameter int FIFO_DEPTH  = 4,
    localparam int TOTAL      = NUM_BLK * BLK_SAMPLES,
    localparam int IW         = $clog2(TOTAL),
    localparam int SH         = $clog2(BLK_SAMPLES),
    localparam int BW         = $clog2(NUM_BLK),
    localparam int CW         = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [NUM_BLK-1:0]        cbp_i,
    input  logic [AW-1:0]             base_i,
    output logic                      ram_rd_en_o,
    output logic [AW-1:0]             ram_addr_o,
    input  logic [mcr_pkg::RES_W-1:0] ram_rdata_i,
    input  logic                      pred_valid_i,
    output logic                      pred_ready_o,
    input  logic [mcr_pkg::PIX_W-1:0] pred_data_i,
    input  logic [BW-1:0]             pred_blk_i,
    output logic                      out_valid_o,
    input  logic                      out_ready_i,
    output logic [mcr_pkg::PIX_W-1:0] out_data_o,
    output logic                      done_o
);
    import mcr_pkg::*;

    logic               busy, go, pop, done_q;
    logic [NUM_BLK-1:0] cbp_q, coded_map;
    logic [AW-1:0]      base_q;
    logic [IW-1:0]      cidx;
    logic [BW-1:0]      cblk;
    logic               push, fifo_empty;
    logic [RES_W-1:0]   push_data, head;
    logic [CW-1:0]      fifo_cnt;

    assign go = start_i && !busy;

    // Reverse the pattern so that block k indexes bit k.
    for (genvar k = 0; k < NUM_BLK; k++) begin : g_map
        assign coded_map[k] = cbp_q[NUM_BLK-1-k];
    end

    // Latch the macroblock set-up and count consumed samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cbp_q  <= '0;
            base_q <= '0;
            cidx   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go) begin
                busy   <= 1'b1;
                cbp_q  <= cbp_i;
                base_q <= base_i;
                cidx   <= '0;
            end else if (pop) begin
                cidx <= cidx + 1'b1;
                if (cidx == IW'(TOTAL - 1)) begin
                    busy   <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    mcr_fetch #(
        .NUM_BLK(NUM_BLK), .BLK_SAMPLES(BLK_SAMPLES), .AW(AW), .DEPTH(FIFO_DEPTH)
    ) i_fetch (
        .clk(clk), .rst_n(rst_n), .go(go), .coded_map(coded_map), .base(base_q),
        .fifo_cnt(fifo_cnt), .ram_rdata(ram_rdata_i), .ram_rd_en(ram_rd_en_o),
        .ram_addr(ram_addr_o), .push(push), .push_data(push_data)
    );

    mcr_fifo #(.W(RES_W), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data), .pop(pop),
        .head(head), .empty(fifo_empty), .count(fifo_cnt)
    );

    assign cblk         = BW'(cidx >> SH);
    assign out_valid_o  = busy && pred_valid_i && !fifo_empty;
    assign pred_ready_o = busy && out_ready_i && !fifo_empty;
    assign pop          = pred_valid_i && pred_ready_o;
    assign out_data_o   = add_pix(pred_data_i, sat_res(head));
    assign done_o       = done_q;

    // R6: an uncoded block passes the prediction through unchanged.
    a_r6_uncoded_pass: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !coded_map[cblk] |-> out_data_o == pred_data_i);
    // R7: the prediction tag names the block currently being rebuilt.
    a_r7_tag_match: assert property (@(posedge clk) disable iff (!rst_n)
        busy && pred_valid_i |-> pred_blk_i == cblk);
    // R8: done lasts one cycle.
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R8: done follows a pixel handshake.
    a_r8_done_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(pop));
    // R10: a start during a busy macroblock leaves the pattern untouched.
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start_i |=> $stable(cbp_q) && $stable(base_q));
endmodule

// File: tb/test_mc_recon.sv
`timescale 1ns/1ps
// Self-checking bench: runs several macroblocks with different patterns,
// bases and stall modes, and compares every pixel and every RAM read with
// values computed arithmetically here.
module test_mc_recon;
    localparam int AW = 10;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [5:0]  cbp_i = '0;
    logic [AW-1:0] base_i = '0;
    logic        ram_rd_en_o;
    logic [AW-1:0] ram_addr_o;
    logic [15:0] ram_rdata_i = '0;
    logic        pred_valid_i = 1'b0;
    logic        pred_ready_o;
    logic [7:0]  pred_data_i = '0;
    logic [2:0]  pred_blk_i = '0;
    logic        out_valid_o;
    logic        out_ready_i = 1'b0;
    logic [7:0]  out_data_o;
    logic        done_o;

    int total = 0;
    int bad = 0;
    int reads_mb = 0;
    int last_off = -1;
    logic [5:0] cur_cbp = '0;
    int cur_base = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    mc_recon #(.AW(AW), .FIFO_DEPTH(DEPTH)) i_mc_recon (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cbp_i(cbp_i), .base_i(base_i),
        .ram_rd_en_o(ram_rd_en_o), .ram_addr_o(ram_addr_o), .ram_rdata_i(ram_rdata_i),
        .pred_valid_i(pred_valid_i), .pred_ready_o(pred_ready_o), .pred_data_i(pred_data_i),
        .pred_blk_i(pred_blk_i), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
        .out_data_o(out_data_o), .done_o(done_o)
    );

    function automatic int res_val(input int a);
        case (a % 7)
            0: return 32767;
            1: return -32768;
            2: return 256;
            3: return -257;
            4: return 255;
            5: return -256;
            default: return (a * 13) % 600 - 300;
        endcase
    endfunction

    function automatic int pred_val(input int s, input int mb);
        if (s % 11 == 0) return 0;
        if (s % 11 == 1) return 255;
        return (s * 29 + mb * 71) % 256;
    endfunction

    function automatic bit is_coded(input logic [5:0] c, input int off);
        return c[5 - off / 64];
    endfunction

    function automatic int next_coded(input logic [5:0] c, input int from);
        for (int o = from; o < 384; o++) if (is_coded(c, o)) return o;
        return -1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // RAM model with one-cycle read latency.
    always @(posedge clk) begin
        if (ram_rd_en_o) ram_rdata_i <= 16'(res_val(int'(ram_addr_o)));
    end

    // Read monitor: window, coded block and address order.
    always @(negedge clk) begin
        if (rst_n && ram_rd_en_o) begin
            int off;
            int nx;
            off = int'(ram_addr_o) - cur_base;
            reads_mb++;
            check(off >= 0 && off < 384 && is_coded(cur_cbp, off), "R2 read in coded slot", off, 0);
            nx = next_coded(cur_cbp, last_off + 1);
            check(off == nx, "R3 read address order", off, nx);
            last_off = off;
        end
    end

    task automatic run_mb(input logic [5:0] c, input int base, input int mode, input int mb,
                          input bit restart);
        int s;
        int exp_reads;
        exp_reads = 0;
        for (int k = 0; k < 6; k++) if (c[k]) exp_reads += 64;
        @(posedge clk); #1;
        reads_mb = 0; last_off = -1; cur_cbp = c; cur_base = base;
        start_i = 1'b1; cbp_i = c; base_i = AW'(base);
        @(posedge clk); #1;
        start_i = 1'b0;
        repeat (10) @(posedge clk);
        @(negedge clk);
        check(reads_mb == (c[5] ? DEPTH : 0), "R9 prefetch depth", reads_mb, c[5] ? DEPTH : 0);
        check(out_valid_o == 1'b0, "R9 no output without prediction", out_valid_o, 0);
        s = 0;
        while (s < 384) begin
            bit pv, ordy;
            @(posedge clk); #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pv   = mode[0] ? (lfsr[0] | lfsr[3]) : 1'b1;
            ordy = mode[1] ? (lfsr[1] | lfsr[5]) : 1'b1;
            if (restart && s >= 100 && s < 110) begin
                start_i = 1'b1; cbp_i = ~c; base_i = AW'(base + 7);
            end else begin
                start_i = 1'b0;
            end
            pred_valid_i = pv;
            pred_data_i  = 8'(pred_val(s, mb));
            pred_blk_i   = 3'(s / 64);
            out_ready_i  = ordy;
            @(negedge clk);
            if (pv && !ordy)
                check(pred_ready_o == 1'b0, "R9 backpressure holds prediction", pred_ready_o, 0);
            if (pred_valid_i && pred_ready_o) begin
                int raw, r9, sum, exp;
                bit cd;
                cd  = is_coded(c, s);
                raw = cd ? res_val(base + s) : 0;
                r9  = raw > 255 ? 255 : (raw < -256 ? -256 : raw);
                sum = pred_val(s, mb) + r9;
                exp = sum < 0 ? 0 : (sum > 255 ? 255 : sum);
                if (!cd)
                    check(out_valid_o && out_data_o == 8'(exp), "R6 R7 uncoded pixel", out_data_o, exp);
                else if (raw != r9)
                    check(out_valid_o && out_data_o == 8'(exp), "R4 R7 clamped residual", out_data_o, exp);
                else
                    check(out_valid_o && out_data_o == 8'(exp), "R5 R7 pixel sum", out_data_o, exp);
                s++;
            end else begin
                check(done_o == 1'b0, "R8 no early done", done_o, 0);
            end
        end
        @(posedge clk); #1;
        pred_valid_i = 1'b0; start_i = 1'b0;
        @(negedge clk);
        check(done_o == 1'b1, "R8 done after last pixel", done_o, 1);
        @(negedge clk);
        check(done_o == 1'b0, "R8 done single cycle", done_o, 0);
        if (restart)
            check(reads_mb == exp_reads, "R10 restart ignored read count", reads_mb, exp_reads);
        else
            check(reads_mb == exp_reads, "R2 read count", reads_mb, exp_reads);
    endtask

    initial begin
        #800000;
        total++; bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        check(!ram_rd_en_o && !out_valid_o && !done_o && !pred_ready_o, "R1 reset state",
              int'({ram_rd_en_o, out_valid_o, done_o, pred_ready_o}), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        pred_valid_i = 1'b1; out_ready_i = 1'b1;
        repeat (3) @(negedge clk);
        check(!ram_rd_en_o && !out_valid_o && !done_o && !pred_ready_o, "R1 idle before start",
              int'({ram_rd_en_o, out_valid_o, done_o, pred_ready_o}), 0);
        @(posedge clk); #1;
        pred_valid_i = 1'b0;
        run_mb(6'h3F, 0,   0, 0, 1'b0);
        run_mb(6'h00, 200, 1, 1, 1'b0);
        run_mb(6'h2A, 640, 2, 2, 1'b0);
        run_mb(6'h15, 100, 3, 3, 1'b1);
        run_mb(6'h01, 0,   3, 4, 1'b0);
        run_mb(6'h20, 333, 1, 5, 1'b0);
        run_mb(6'h3F, 640, 3, 6, 1'b1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule